// File: doc/BRIEF.md
# Gray-Phased Three-Cycle Datapath

This block moves one data word at a time through a launch register, an incrementer and a capture register. A free-running two-bit phase counter, stepped in Gray order, decides when each register may load. The launch register accepts a new input word only on the edge that ends the first phase. The capture register accepts the incremented word only on the edge that ends the fourth phase. The incrementer between the two registers therefore has three full clock periods to settle.

The output is the capture register. The current phase is exposed so that a user can tell when the input will be sampled and when the output is fresh. A synchronous reset returns the counter to its first phase and clears both data registers.

Top module: `gray_mc_datapath`

## Requirements
- R1: While `rst` is high, every clock edge sets `phase` to 2'b00 and `dataOut` to zero.
- R2: Out of reset, `phase` repeats the sequence 2'b00, 2'b01, 2'b11, 2'b10 and then returns to 2'b00, advancing one step on every rising clock edge.
- R3: On the rising edge at which `phase` leaves 2'b00, the launch register takes the value of `dataIn`.
- R4: The value of `dataIn` at edges where `phase` is 2'b01, 2'b11 or 2'b10 has no effect on any later `dataOut`.
- R5: On the edge at which `phase` goes from 2'b10 to 2'b00, `dataOut` becomes the launch register plus one, modulo 2^DATA_W.
- R6: `dataOut` holds its value across every edge at which `phase` is not 2'b10.
- R7: A launched all-ones word produces a captured value of zero, because the sum wraps.
- R8: The launch register does not change during the three clock periods between the launch edge and the next capture edge.
- R9: A reset applied in the middle of a transfer restarts the sequence at 2'b00 with `dataOut` at zero. The next word launched after the reset is then delivered normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | DATA_W | Word sampled at the end of phase 2'b00 |
| dataOut | output | DATA_W | Captured result, launch word plus one |
| phase | output | 2 | Current Gray phase |

## Verification
The hardest situation to reach is a launch register that stays frozen while `dataIn` keeps changing. The bench cannot see the launch register, so it shows R8 and R4 indirectly. During each of the three non-launch phases it drives a different word on `dataIn`, each unrelated to the launched one. It then checks that the captured result still matches only the word present at the launch edge. Every possible 8-bit word is launched once, which covers the wrap case. A reset asserted in phase 2'b11 checks that an interrupted transfer is abandoned.

// File: rtl/gsd_pkg.sv
package gsd_pkg;

  typedef enum logic [1:0] {
    PH_LOAD   = 2'b00,
    PH_HOLD_A = 2'b01,
    PH_HOLD_B = 2'b11,
    PH_STORE  = 2'b10
  } phase_e;

  typedef struct packed {
    logic launchEn;
    logic captureEn;
  } strobe_t;

  function automatic phase_e nextPhase(input phase_e cur);
    phase_e nxt;
    case (cur)
      PH_LOAD:   nxt = PH_HOLD_A;
      PH_HOLD_A: nxt = PH_HOLD_B;
      PH_HOLD_B: nxt = PH_STORE;
      default:   nxt = PH_LOAD;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/gsd_phase_ctrl.sv
module gsd_phase_ctrl
  import gsd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  output phase_e  phaseQ,
  output strobe_t strobes
);

  phase_e phaseD;

  always_comb phaseD = nextPhase(phaseQ);

  always_ff @(posedge clk) begin
    if (rst) phaseQ <= PH_LOAD;
    else     phaseQ <= phaseD;
  end

  always_comb begin
    strobes.launchEn  = (phaseQ == PH_LOAD);
    strobes.captureEn = (phaseQ == PH_STORE);
  end

endmodule

// File: rtl/gsd_datapath.sv
module gsd_datapath
  import gsd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STEP   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] launchQ,
  output logic [DATA_W-1:0] captureQ
);

  localparam logic [DATA_W-1:0] STEP_W = DATA_W'(STEP);

  logic [DATA_W-1:0] launchD;
  logic [DATA_W-1:0] sumSlow;
  logic [DATA_W-1:0] captureD;

  always_comb launchD = strobes.launchEn ? dataIn : launchQ;

  // Combinational function: this is the path that gets three cycles to settle.
  always_comb sumSlow = launchQ + STEP_W;

  always_comb captureD = strobes.captureEn ? sumSlow : captureQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      launchQ  <= '0;
      captureQ <= '0;
    end else begin
      launchQ  <= launchD;
      captureQ <= captureD;
    end
  end

endmodule

// File: rtl/gray_mc_datapath.sv
module gray_mc_datapath
  import gsd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [1:0]        phase
);

  phase_e            phaseQ;
  strobe_t           strobes;
  logic [DATA_W-1:0] launchQ;

  gsd_phase_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .phaseQ  (phaseQ),
    .strobes (strobes)
  );

  gsd_datapath #(.DATA_W(DATA_W), .STEP(1)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .dataIn   (dataIn),
    .launchQ  (launchQ),
    .captureQ (dataOut)
  );

  assign phase = phaseQ;

endmodule

// File: rtl/gray_mc_datapath_chk.sv
module gray_mc_datapath_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        phase,
  input logic [DATA_W-1:0] dataIn,
  input logic [DATA_W-1:0] launchQ,
  input logic [DATA_W-1:0] dataOut
);

  a_r2_step_from_load: assert property (@(posedge clk) disable iff (rst)
    phase == 2'b00 |=> phase == 2'b01);
  a_r2_step_from_a: assert property (@(posedge clk) disable iff (rst)
    phase == 2'b01 |=> phase == 2'b11);
  a_r2_step_from_b: assert property (@(posedge clk) disable iff (rst)
    phase == 2'b11 |=> phase == 2'b10);
  a_r2_step_from_store: assert property (@(posedge clk) disable iff (rst)
    phase == 2'b10 |=> phase == 2'b00);
  a_r2_one_bit_change: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(phase ^ $past(phase)) == 1);

  a_r3_launch_takes_input: assert property (@(posedge clk) disable iff (rst)
    phase == 2'b00 |=> launchQ == $past(dataIn));

  a_r8_launch_frozen: assert property (@(posedge clk) disable iff (rst)
    phase != 2'b00 |=> $stable(launchQ));

  a_r5_capture_increment: assert property (@(posedge clk) disable iff (rst)
    phase == 2'b10 |=> dataOut == DATA_W'($past(launchQ) + 1'b1));

  a_r6_output_holds: assert property (@(posedge clk) disable iff (rst)
    phase != 2'b10 |=> $stable(dataOut));

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (phase == 2'b00 && dataOut == '0));

endmodule

bind gray_mc_datapath gray_mc_datapath_chk #(.DATA_W(DATA_W)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .phase   (phase),
  .dataIn  (dataIn),
  .launchQ (launchQ),
  .dataOut (dataOut)
);

// File: tb/test_gray_mc_datapath.sv
module test_gray_mc_datapath;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] dataOut;
  logic [1:0]   phase;

  int  vecCount = 0;
  int  errCount = 0;
  bit  finished = 1'b0;

  gray_mc_datapath #(.DATA_W(W)) i_gray_mc_datapath (
    .clk     (clk),
    .rst     (rst),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .phase   (phase)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  endtask

  // One full transfer, entered at a falling edge with phase 00.
  task automatic transfer(input logic [W-1:0] v, inout logic [W-1:0] expOut);
    check("R2 phase 00", 32'(phase), 32'h0);
    dataIn = v;
    @(negedge clk);
    check("R2 phase 01", 32'(phase), 32'h1);
    check("R6 hold after launch", 32'(dataOut), 32'(expOut));
    dataIn = ~v;                       // R4 disturbance
    @(negedge clk);
    check("R2 phase 11", 32'(phase), 32'h3);
    check("R6 hold mid", 32'(dataOut), 32'(expOut));
    dataIn = v ^ 8'h5A;                // R4 disturbance
    @(negedge clk);
    check("R2 phase 10", 32'(phase), 32'h2);
    check("R6 hold before capture", 32'(dataOut), 32'(expOut));
    dataIn = v + 8'd77;                // R4 disturbance
    @(negedge clk);
    expOut = W'(v + 1);
    check("R3 R4 R5 captured increment", 32'(dataOut), 32'(expOut));
    if (v == '1) check("R7 wrap to zero", 32'(dataOut), 32'h0);
  endtask

  initial begin
    #2_000_000;
    errCount++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    logic [W-1:0] expOut;
    expOut = '0;
    repeat (3) @(negedge clk);
    check("R1 reset phase", 32'(phase), 32'h0);
    check("R1 reset output", 32'(dataOut), 32'h0);
    rst = 1'b0;

    for (int v = 0; v < (1 << W); v++) begin
      transfer(W'(v), expOut);
    end

    // R9: reset in the middle of a transfer
    dataIn = 8'h3C;
    @(negedge clk);
    @(negedge clk);
    check("R9 pre-reset phase 11", 32'(phase), 32'h3);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 phase restarted", 32'(phase), 32'h0);
    check("R9 output cleared", 32'(dataOut), 32'h0);
    rst = 1'b0;
    expOut = '0;
    transfer(8'hA7, expOut);
    check("R9 delivery after reset", 32'(dataOut), 32'hA8);
    finish();
  end

endmodule